// File: doc/BRIEF.md
# Mirrored-Plane Path Selector

This block chooses, per connection, which of two switching planes with identical topology should carry a signal. Both planes are built from 2×2 elements. In the normal plane the bar setting is the lossy one; in the mirrored plane every element has its two loss states swapped. A connection that meets X lossy elements out of S elements in the normal plane therefore meets S − X lossy elements in the mirrored plane.

The block receives the element settings that a path computer produced for the normal plane, one bit per traversed element, together with a strobe. It counts the lossy elements and picks the plane with fewer of them. If the count is exactly half of S, it keeps the normal plane. It adds the fixed penalty of the plane selector in front of the planes and reports that total as the degradation of the connection. A connection whose degradation is greater than a programmed ceiling is flagged as blocked. All results appear one clock after the strobe.

With a Benes plane of 2·log2(N) − 1 stages and a selector that costs one lossy element, the worst connection ends at log2(N). A selector folded into a crossbar stage costs nothing, so the penalty is an input and zero is a legal value.

Top module: `mirror_plane_selector`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each clock edge at which `in_valid` was sampled high, and low otherwise.
- R2: The lossy count X is the number of ones in `in_states`. Bit i is the setting of the i-th traversed element, and 1 means bar (lossy in the normal plane). `out_mirror` is 1 when 2·X > STAGES and 0 otherwise.
- R3: When 2·X equals STAGES exactly, which can only happen for an even STAGES, `out_mirror` is 0 (normal plane).
- R4: `out_degrade` equals `sel_penalty` plus X when `out_mirror` is 0, and plus STAGES − X when `out_mirror` is 1.
- R5: For every input pattern, `out_degrade` ≤ floor(STAGES/2) + `sel_penalty`. With STAGES = 7 and a penalty of 1, the worst pattern reaches exactly 4. An all-zero pattern and an all-one pattern both give `sel_penalty`.
- R6: `out_blocked` is 1 exactly when `out_degrade` is greater than the `deg_limit` sampled with the strobe. A degradation equal to the limit is not blocked.
- R7: While `in_valid` is low, `out_mirror`, `out_degrade` and `out_blocked` keep their last values, whatever `in_states`, `sel_penalty` and `deg_limit` do.
- R8: While `rst_n` is low, all outputs are 0.
- R9: A `sel_penalty` of 0 is accepted, and `out_degrade` is then the plane count alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: a path state vector is present |
| in_states | input | STAGES | Normal-plane element settings, 1 = bar |
| sel_penalty | input | PEN_W | Lossy elements added by the plane selector |
| deg_limit | input | DEG_W | Largest degradation that is not blocked |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_mirror | output | 1 | Chosen plane: 0 normal, 1 mirrored |
| out_degrade | output | DEG_W | Final degradation of the connection |
| out_blocked | output | 1 | Degradation exceeds `deg_limit` |

## Verification
A miscounted group of element bits shows up at the ports one clock after the strobe. It appears as a degradation that is off from the reference count, and often as a plane bit on the wrong side of S/2. A full sweep of every state pattern exposes it within the first few hundred cycles. A wrong tie rule or a wrong limit comparison is visible only for patterns at exactly half or at exactly the limit, so those are driven on purpose. A result register that loads without a strobe shows as outputs that change while the strobe is low, which the hold scenario catches within two cycles.

// File: rtl/mps_pkg.sv
package mps_pkg;
   typedef enum logic {
      PLANE_NORMAL = 1'b0,
      PLANE_MIRROR = 1'b1
   } plane_e;

   // largest degradation for a given stage count and penalty width
   function automatic int max_degrade(input int stages, input int pen_w);
      return (stages / 2) + (1 << pen_w) - 1;
   endfunction

   // bits needed to hold values 0..v
   function automatic int bits_for(input int v);
      int w;
      w = 1;
      while ((1 << w) <= v) w++;
      return w;
   endfunction
endpackage

// File: rtl/mps_hl_counter.sv
module mps_hl_counter #(
   parameter int STAGES = 7,
   parameter int GROUP  = 4,
   parameter int CNT_W  = 3
) (
   input  logic [STAGES-1:0] states,
   output logic [CNT_W-1:0]  hl_cnt
);
   localparam int NGRP = (STAGES + GROUP - 1) / GROUP;

   if (GROUP < 1) begin : g_bad_group
      $error("mps_hl_counter: GROUP must be at least 1");
   end
   if ((1 << CNT_W) <= STAGES) begin : g_bad_width
      $error("mps_hl_counter: CNT_W too small for STAGES");
   end

   if (NGRP == 1) begin : g_flat
      // single group: one linear count over all bits
      always_comb begin
         hl_cnt = '0;
         for (int b = 0; b < STAGES; b++) hl_cnt = hl_cnt + CNT_W'(states[b]);
      end
   end else begin : g_grouped
      // per-group counts chained through a running sum
      logic [NGRP:0][CNT_W-1:0] acc;
      assign acc[0] = '0;
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         localparam int LO = g * GROUP;
         localparam int HI = (LO + GROUP > STAGES) ? STAGES : LO + GROUP;
         logic [CNT_W-1:0] part;
         always_comb begin
            part = '0;
            for (int b = LO; b < HI; b++) part = part + CNT_W'(states[b]);
         end
         assign acc[g+1] = acc[g] + part;
      end
      assign hl_cnt = acc[NGRP];
   end
endmodule

// File: rtl/mps_plane_decide.sv
module mps_plane_decide
   import mps_pkg::*;
#(
   parameter int STAGES = 7,
   parameter int CNT_W  = 3
) (
   input  logic [CNT_W-1:0] hl_cnt,
   output plane_e           plane,
   output logic [CNT_W-1:0] plane_cnt
);
   localparam int DW = CNT_W + 1;
   localparam logic [DW-1:0] S_EXT = DW'(STAGES);
   localparam logic [CNT_W-1:0] S_CNT = CNT_W'(STAGES);

   logic [DW-1:0] doubled;

   always_comb begin
      doubled = {hl_cnt, 1'b0};
      // strict comparison keeps the normal plane on an exact half
      plane = (doubled > S_EXT) ? PLANE_MIRROR : PLANE_NORMAL;
      plane_cnt = (plane == PLANE_MIRROR) ? (S_CNT - hl_cnt) : hl_cnt;
   end
endmodule

// File: rtl/mps_degrade_eval.sv
module mps_degrade_eval #(
   parameter int CNT_W = 3,
   parameter int PEN_W = 2,
   parameter int DEG_W = 3
) (
   input  logic [CNT_W-1:0] plane_cnt,
   input  logic [PEN_W-1:0] penalty,
   input  logic [DEG_W-1:0] limit,
   output logic [DEG_W-1:0] degrade,
   output logic             blocked
);
   if (DEG_W < CNT_W || DEG_W < PEN_W) begin : g_bad_width
      $error("mps_degrade_eval: DEG_W narrower than an addend");
   end

   always_comb begin
      degrade = DEG_W'(plane_cnt) + DEG_W'(penalty);
      blocked = degrade > limit;
   end
endmodule

// File: rtl/mirror_plane_selector.sv
module mirror_plane_selector
   import mps_pkg::*;
#(
   parameter int STAGES = 7,
   parameter int PEN_W  = 2,
   parameter int GROUP  = 4,
   parameter int DEG_W  = mps_pkg::bits_for(mps_pkg::max_degrade(STAGES, PEN_W))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [STAGES-1:0] in_states,
   input  logic [PEN_W-1:0]  sel_penalty,
   input  logic [DEG_W-1:0]  deg_limit,
   output logic              out_valid,
   output logic              out_mirror,
   output logic [DEG_W-1:0]  out_degrade,
   output logic              out_blocked
);
   localparam int CNT_W = bits_for(STAGES);

   if (STAGES < 1) begin : g_bad_stages
      $error("mirror_plane_selector: STAGES must be at least 1");
   end
   if (PEN_W < 1) begin : g_bad_pen
      $error("mirror_plane_selector: PEN_W must be at least 1");
   end
   if ((1 << DEG_W) <= max_degrade(STAGES, PEN_W)) begin : g_bad_deg
      $error("mirror_plane_selector: DEG_W cannot hold the worst degradation");
   end

   logic [CNT_W-1:0] hl_cnt;
   logic [CNT_W-1:0] plane_cnt;
   plane_e           plane;
   logic [DEG_W-1:0] degrade_c;
   logic             blocked_c;

   mps_hl_counter #(
      .STAGES (STAGES),
      .GROUP  (GROUP),
      .CNT_W  (CNT_W)
   ) u_count (
      .states (in_states),
      .hl_cnt (hl_cnt)
   );

   mps_plane_decide #(
      .STAGES (STAGES),
      .CNT_W  (CNT_W)
   ) u_decide (
      .hl_cnt    (hl_cnt),
      .plane     (plane),
      .plane_cnt (plane_cnt)
   );

   mps_degrade_eval #(
      .CNT_W (CNT_W),
      .PEN_W (PEN_W),
      .DEG_W (DEG_W)
   ) u_eval (
      .plane_cnt (plane_cnt),
      .penalty   (sel_penalty),
      .limit     (deg_limit),
      .degrade   (degrade_c),
      .blocked   (blocked_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_mirror  <= 1'b0;
         out_degrade <= '0;
         out_blocked <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_mirror  <= (plane == PLANE_MIRROR);
            out_degrade <= degrade_c;
            out_blocked <= blocked_c;
         end
      end
   end
endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
   parameter int STAGES = 7,
   parameter int PEN_W  = 2,
   parameter int DEG_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [STAGES-1:0] in_states,
   input logic [PEN_W-1:0]  sel_penalty,
   input logic [DEG_W-1:0]  deg_limit,
   input logic              out_valid,
   input logic              out_mirror,
   input logic [DEG_W-1:0]  out_degrade,
   input logic              out_blocked
);
   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R2
   plane_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_mirror == (2 * $countones($past(in_states)) > STAGES)));
   // R4
   degrade_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (int'(out_degrade) == int'($past(sel_penalty)) +
         (out_mirror ? STAGES - $countones($past(in_states))
                     : $countones($past(in_states)))));
   // R5
   degrade_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (int'(out_degrade) <= STAGES / 2 + int'($past(sel_penalty))));
   // R6
   blocked_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_blocked == (out_degrade > $past(deg_limit))));
   // R7
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable({out_mirror, out_degrade, out_blocked}));
   // R8
   always_comb begin
      if (!rst_n) begin
         reset_clear_chk: assert (!out_valid && !out_mirror && out_degrade == '0 && !out_blocked);
      end
   end
endmodule

bind mirror_plane_selector mps_checker #(
   .STAGES (STAGES),
   .PEN_W  (PEN_W),
   .DEG_W  (DEG_W)
) u_mps_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_states   (in_states),
   .sel_penalty (sel_penalty),
   .deg_limit   (deg_limit),
   .out_valid   (out_valid),
   .out_mirror  (out_mirror),
   .out_degrade (out_degrade),
   .out_blocked (out_blocked)
);

// File: tb/mirror_plane_selector_test.sv
module mirror_plane_selector_test;
   localparam int S  = 7;
   localparam int SE = 6;
   localparam int PW = 2;
   localparam int DW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          in_valid = 1'b0;
   logic [S-1:0]  in_states = '0;
   logic [PW-1:0] sel_penalty = '0;
   logic [DW-1:0] deg_limit = '0;
   logic          out_valid, out_mirror, out_blocked;
   logic [DW-1:0] out_degrade;

   logic          e_valid = 1'b0;
   logic [SE-1:0] e_states = '0;
   logic [PW-1:0] e_pen = '0;
   logic [DW-1:0] e_lim = '0;
   logic          e_ovalid, e_mirror, e_blocked;
   logic [DW-1:0] e_degrade;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   mirror_plane_selector #(.STAGES(S), .PEN_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_states(in_states),
      .sel_penalty(sel_penalty), .deg_limit(deg_limit), .out_valid(out_valid),
      .out_mirror(out_mirror), .out_degrade(out_degrade), .out_blocked(out_blocked));

   mirror_plane_selector #(.STAGES(SE), .PEN_W(PW)) uut_even (
      .clk(clk), .rst_n(rst_n), .in_valid(e_valid), .in_states(e_states),
      .sel_penalty(e_pen), .deg_limit(e_lim), .out_valid(e_ovalid),
      .out_mirror(e_mirror), .out_degrade(e_degrade), .out_blocked(e_blocked));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ones(input logic [S-1:0] v, input int n);
      int c = 0;
      for (int i = 0; i < n; i++) c += int'(v[i]);
      return c;
   endfunction

   // drive one strobe on uut, return after the result edge (at a falling edge)
   task automatic drive(input logic [S-1:0] st, input int pen, input int lim);
      @(negedge clk);
      in_states = st; sel_penalty = PW'(pen); deg_limit = DW'(lim); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_uut(input string tag, input logic [S-1:0] st, input int pen, input int lim);
      int x, m, d;
      x = ones(st, S);
      m = (2 * x > S) ? 1 : 0;
      d = pen + (m == 1 ? S - x : x);
      check({tag, " plane"}, int'(out_mirror), m);
      check({tag, " degrade"}, int'(out_degrade), d);
      check({tag, " blocked"}, int'(out_blocked), (d > lim) ? 1 : 0);
   endtask

   task automatic t_reset();
      #1;
      check("R8 valid", int'(out_valid), 0);
      check("R8 plane", int'(out_mirror), 0);
      check("R8 degrade", int'(out_degrade), 0);
      check("R8 blocked", int'(out_blocked), 0);
   endtask

   task automatic t_timing();
      @(negedge clk);
      in_states = 7'b1111000; sel_penalty = 2'd1; deg_limit = 3'd7; in_valid = 1'b1;
      check("R1 before edge", int'(out_valid), 0);
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 one cycle later", int'(out_valid), 1);
      @(negedge clk);
      check("R1 drops after strobe", int'(out_valid), 0);
   endtask

   task automatic t_sweep();
      int worst = 0;
      for (int p = 0; p < (1 << S); p++) begin
         drive(S'(p), 1, 3);
         expect_uut("R2 R4 R6 sweep", S'(p), 1, 3);
         if (int'(out_degrade) > worst) worst = int'(out_degrade);
      end
      check("R5 worst case with penalty 1", worst, 4);
   endtask

   task automatic t_extremes();
      drive('1, 2, 7);
      check("R5 all bar plane", int'(out_mirror), 1);
      check("R5 all bar degrade", int'(out_degrade), 2);
      drive('0, 2, 7);
      check("R5 all cross plane", int'(out_mirror), 0);
      check("R5 all cross degrade", int'(out_degrade), 2);
   endtask

   task automatic t_limit();
      drive(7'b0000111, 1, 4);
      check("R6 equal limit not blocked", int'(out_blocked), 0);
      drive(7'b0000111, 1, 3);
      check("R6 one over limit blocked", int'(out_blocked), 1);
   endtask

   task automatic t_zero_pen();
      drive(7'b0100101, 0, 7);
      expect_uut("R9 zero penalty", 7'b0100101, 0, 7);
      drive(7'b1101101, 0, 7);
      check("R9 zero penalty mirrored", int'(out_degrade), 2);
   endtask

   task automatic t_hold();
      drive(7'b1110110, 3, 2);
      expect_uut("R7 loaded", 7'b1110110, 3, 2);
      @(negedge clk);
      in_states = 7'b0000001; sel_penalty = 2'd0; deg_limit = 3'd7;
      @(negedge clk);
      @(negedge clk);
      check("R7 plane held", int'(out_mirror), 1);
      check("R7 degrade held", int'(out_degrade), 5);
      check("R7 blocked held", int'(out_blocked), 1);
   endtask

   task automatic t_tie();
      @(negedge clk);
      e_states = 6'b010101; e_pen = 2'd1; e_lim = 3'd7; e_valid = 1'b1;
      @(negedge clk);
      e_valid = 1'b0;
      check("R3 exact half keeps normal", int'(e_mirror), 0);
      check("R3 exact half degrade", int'(e_degrade), 4);
      @(negedge clk);
      e_states = 6'b011101; e_valid = 1'b1;
      @(negedge clk);
      e_valid = 1'b0;
      check("R3 above half mirrored", int'(e_mirror), 1);
      check("R3 above half degrade", int'(e_degrade), 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_timing();
      t_sweep();
      t_extremes();
      t_limit();
      t_zero_pen();
      t_hold();
      t_tie();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule